// File: doc/BRIEF.md
# Interrupt Mask and Pending Controller

This block sits between the interrupt sources of a small 8-bit microcontroller and its core. It watches an active-low external pin and a one-cycle timer overflow pulse, records their events in pending flags, and gates them with per-source enable bits and a single global enable. When the global enable is on and at least one enabled source is requesting, it offers the core one vector. The core consumes the offer with a valid/ready handshake. Software reaches every mask, flag and the global enable through a small byte-wide I/O register port.

The vector offer is a stream of one-beat transfers. `irq_valid` rises only when no offer is outstanding. Once raised, it and `irq_vector` stay frozen until the cycle in which `irq_ready` is also high. That cycle is the handshake, and the offer drops on the next edge. The core may hold `irq_ready` low for any number of cycles, and may hold it high while no offer is present. An offer that has been made is committed: later mask, flag or global-enable changes do not withdraw it.

Accepting a vector clears the global enable and the pending flag of the vectored source. A return pulse from the core sets the global enable again. The external source can be switched to level mode. In that mode it keeps no flag and requests only while the pin is held low. Status register saving is left to software.

Top module: `irq_frontend`

## Requirements
- R1: After reset, every mask bit, every pending flag and the global enable read as zero, and `irq_valid` is low.
- R2: Register map, all eight bits wide with unlisted bits reading zero and ignoring writes.
  - 0x3B: bit 6 is the external enable.
  - 0x39: bit 1 is the timer enable.
  - 0x3A: bit 6 is the external pending flag.
  - 0x38: bit 1 is the timer pending flag.
  - 0x3F: bit 7 is the global enable.
  - Any other address reads 0x00.
- R3: In edge mode (`ext0_level`=0), a clock edge at which `ext0_n` samples 0, after sampling 1 at the previous edge, sets the external flag. A clock edge with `tov_pulse`=1 sets the timer flag. Both happen whatever the enables and the global enable are.
- R4: Writing a one to a flag bit clears that flag, and writing zero leaves it. If a new event arrives in the same cycle as the clear, the flag stays set.
- R5: When no offer is outstanding, the global enable is 1 and an enabled source is requesting, `irq_valid` rises at the next edge. The vector is 1 for the external source and 2 for the timer.
- R6: When both sources request at once, the external source (vector 1) is offered first.
- R7: While `irq_valid` is high and `irq_ready` is low, `irq_valid` and `irq_vector` hold unchanged.
- R8: A handshake clears the global enable at that edge, even if software writes a one to it in the same cycle.
- R9: A handshake clears the pending flag of the vectored source and leaves the other flag unchanged.
- R10: A `reti` pulse sets the global enable at that edge, unless a handshake happens in the same cycle.
- R11: In level mode (`ext0_level`=1), the external flag reads zero and is never set. The external source requests exactly while `ext0_n` is 0, and a request whose pin has returned high is not offered again.
- R12: A flag set while its enable or the global enable is off is remembered and is offered once both are on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext0_n | input | 1 | External interrupt pin, active low, synchronous to clk |
| ext0_level | input | 1 | 1 selects level mode for the external source, 0 selects falling-edge mode |
| tov_pulse | input | 1 | One-cycle timer overflow event |
| io_addr | input | 6 | I/O register address |
| io_wr | input | 1 | I/O write strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data, combinational from io_addr |
| irq_valid | output | 1 | Vector offer valid |
| irq_vector | output | 2 | Offered vector (1 external, 2 timer) |
| irq_ready | input | 1 | Core accepts the offer when high with irq_valid |
| reti | input | 1 | Return-from-interrupt pulse from the core |

## Verification
The bench targets the following corner cases, each paired with the fault it would expose:
- A software write of one to the global enable in the handshake cycle. A design with the wrong precedence would immediately offer the timer vector after the external one.
- A flag clear coinciding with a fresh pin edge. Clear-wins logic would silently drop the interrupt.
- Holding `irq_ready` low across several cycles while the lower-priority flag is also pending. A design that re-arbitrates each cycle would show a changing vector or a dropping valid.
- Level mode with the pin released after service. A design that latched the level into a flag would offer the external vector a second time.

A random phase then compares every output against a behavioural model on each cycle.

// File: rtl/irq_fe_pkg.sv
package irq_fe_pkg;
  localparam int NSRC     = 2;
  localparam int SRC_EXT0 = 0;
  localparam int SRC_TOV  = 1;
  localparam int VEC_W    = $clog2(NSRC + 1);
  typedef logic [VEC_W-1:0] vec_t;
endpackage

// File: rtl/irq_fe_flags.sv
module irq_fe_flags
  import irq_fe_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ext0_n,
  input  logic            ext0_level,
  input  logic            tov_pulse,
  input  logic [NSRC-1:0] sw_clr,
  input  logic [NSRC-1:0] hw_clr,
  output logic [NSRC-1:0] flag
);
  logic            pin_q;
  logic [NSRC-1:0] evt;
  logic [NSRC-1:0] kill;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b1;
    else        pin_q <= ext0_n;
  end

  always_comb begin
    evt = '0;
    kill = '0;
    evt[SRC_EXT0]  = pin_q & ~ext0_n & ~ext0_level;
    evt[SRC_TOV]   = tov_pulse;
    kill[SRC_EXT0] = ext0_level;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag[i] <= 1'b0;
      else if (kill[i]) flag[i] <= 1'b0;
      else              flag[i] <= (flag[i] & ~(sw_clr[i] | hw_clr[i])) | evt[i];
    end
  end
endmodule

// File: rtl/irq_fe_regs.sv
module irq_fe_regs
  import irq_fe_pkg::*;
#(
  parameter int          ADDR_W  = 6,
  parameter int          DATA_W  = 8,
  parameter logic [5:0]  A_GMASK = 6'h3B,
  parameter logic [5:0]  A_TMASK = 6'h39,
  parameter logic [5:0]  A_GFLAG = 6'h3A,
  parameter logic [5:0]  A_TFLAG = 6'h38,
  parameter logic [5:0]  A_STAT  = 6'h3F,
  parameter int          B_EXT0  = 6,
  parameter int          B_TOV   = 1,
  parameter int          B_GIE   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  input  logic [NSRC-1:0]   flag,
  input  logic              accept,
  input  logic              reti,
  output logic [NSRC-1:0]   en,
  output logic              gie,
  output logic [NSRC-1:0]   sw_clr
);
  logic wr_gmask, wr_tmask, wr_stat;

  assign wr_gmask = io_wr && (io_addr == ADDR_W'(A_GMASK));
  assign wr_tmask = io_wr && (io_addr == ADDR_W'(A_TMASK));
  assign wr_stat  = io_wr && (io_addr == ADDR_W'(A_STAT));

  always_comb begin
    sw_clr = '0;
    sw_clr[SRC_EXT0] = io_wr && (io_addr == ADDR_W'(A_GFLAG)) && io_wdata[B_EXT0];
    sw_clr[SRC_TOV]  = io_wr && (io_addr == ADDR_W'(A_TFLAG)) && io_wdata[B_TOV];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en  <= '0;
      gie <= 1'b0;
    end else begin
      if (wr_gmask) en[SRC_EXT0] <= io_wdata[B_EXT0];
      if (wr_tmask) en[SRC_TOV]  <= io_wdata[B_TOV];
      if (wr_stat)  gie <= io_wdata[B_GIE];
      if (reti)     gie <= 1'b1;
      if (accept)   gie <= 1'b0;
    end
  end

  always_comb begin
    io_rdata = '0;
    if (io_addr == ADDR_W'(A_GMASK)) io_rdata[B_EXT0] = en[SRC_EXT0];
    if (io_addr == ADDR_W'(A_TMASK)) io_rdata[B_TOV]  = en[SRC_TOV];
    if (io_addr == ADDR_W'(A_GFLAG)) io_rdata[B_EXT0] = flag[SRC_EXT0];
    if (io_addr == ADDR_W'(A_TFLAG)) io_rdata[B_TOV]  = flag[SRC_TOV];
    if (io_addr == ADDR_W'(A_STAT))  io_rdata[B_GIE]  = gie;
  end
endmodule

// File: rtl/irq_fe_arb.sv
module irq_fe_arb
  import irq_fe_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] en,
  input  logic [NSRC-1:0] flag,
  input  logic            gie,
  input  logic            ext0_n,
  input  logic            ext0_level,
  output logic            irq_valid,
  output vec_t            irq_vector,
  input  logic            irq_ready,
  output logic            accept,
  output logic [NSRC-1:0] take
);
  logic [NSRC-1:0] req;
  vec_t            pick;

  always_comb begin
    req = en & flag;
    req[SRC_EXT0] = en[SRC_EXT0] & (ext0_level ? ~ext0_n : flag[SRC_EXT0]);
  end

  // lowest source index wins: scan downward so the last hit is the winner
  always_comb begin
    pick = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req[i]) pick = VEC_W'(i + 1);
    end
  end

  assign accept = irq_valid && irq_ready;

  for (genvar i = 0; i < NSRC; i++) begin : g_take
    assign take[i] = accept && (irq_vector == VEC_W'(i + 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_valid  <= 1'b0;
      irq_vector <= '0;
    end else if (accept) begin
      irq_valid  <= 1'b0;
    end else if (!irq_valid && gie && (|req)) begin
      irq_valid  <= 1'b1;
      irq_vector <= pick;
    end
  end
endmodule

// File: rtl/irq_frontend.sv
module irq_frontend
  import irq_fe_pkg::*;
#(
  parameter int          ADDR_W  = 6,
  parameter int          DATA_W  = 8,
  parameter logic [5:0]  A_GMASK = 6'h3B,
  parameter logic [5:0]  A_TMASK = 6'h39,
  parameter logic [5:0]  A_GFLAG = 6'h3A,
  parameter logic [5:0]  A_TFLAG = 6'h38,
  parameter logic [5:0]  A_STAT  = 6'h3F,
  parameter int          B_EXT0  = 6,
  parameter int          B_TOV   = 1,
  parameter int          B_GIE   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext0_n,
  input  logic              ext0_level,
  input  logic              tov_pulse,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  output logic              irq_valid,
  output logic [VEC_W-1:0]  irq_vector,
  input  logic              irq_ready,
  input  logic              reti
);
  logic [NSRC-1:0] flag, en, sw_clr, take;
  logic            gie, accept;

  irq_fe_flags u_flags (
    .clk, .rst_n, .ext0_n, .ext0_level, .tov_pulse,
    .sw_clr, .hw_clr(take), .flag
  );

  irq_fe_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .A_GMASK(A_GMASK), .A_TMASK(A_TMASK), .A_GFLAG(A_GFLAG),
    .A_TFLAG(A_TFLAG), .A_STAT(A_STAT),
    .B_EXT0(B_EXT0), .B_TOV(B_TOV), .B_GIE(B_GIE)
  ) u_regs (
    .clk, .rst_n, .io_addr, .io_wr, .io_wdata, .io_rdata,
    .flag, .accept, .reti, .en, .gie, .sw_clr
  );

  irq_fe_arb u_arb (
    .clk, .rst_n, .en, .flag, .gie, .ext0_n, .ext0_level,
    .irq_valid, .irq_vector, .irq_ready, .accept, .take
  );
endmodule

// File: rtl/irq_frontend_chk.sv
module irq_frontend_chk
  import irq_fe_pkg::*;
#(
  parameter int          ADDR_W  = 6,
  parameter int          DATA_W  = 8,
  parameter logic [5:0]  A_GMASK = 6'h3B,
  parameter int          B_EXT0  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_valid,
  input logic              irq_ready,
  input logic [VEC_W-1:0]  irq_vector,
  input logic              reti,
  input logic              gie,
  input logic [ADDR_W-1:0] io_addr,
  input logic [DATA_W-1:0] io_rdata
);
  a_r7_offer_held: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && !irq_ready |=> irq_valid && $stable(irq_vector));

  a_r8_accept_drops_gie: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && irq_ready |=> !gie && !irq_valid);

  a_r10_reti_raises_gie: assert property (@(posedge clk) disable iff (!rst_n)
    reti && !(irq_valid && irq_ready) |=> gie);

  a_r5_vector_named: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_vector != '0));

  a_r5_offer_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_valid) |-> $past(gie));

  a_r2_mask_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (io_addr == ADDR_W'(A_GMASK)) |-> ((io_rdata & ~(DATA_W'(1) << B_EXT0)) == '0));
endmodule

bind irq_frontend irq_frontend_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .A_GMASK(A_GMASK), .B_EXT0(B_EXT0)
) u_chk (
  .clk, .rst_n, .irq_valid, .irq_ready, .irq_vector, .reti, .gie,
  .io_addr, .io_rdata
);

// File: tb/irq_frontend_tb_top.sv
`timescale 1ns/1ps
module irq_frontend_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext0_n = 1'b1, ext0_level = 1'b0, tov_pulse = 1'b0;
  logic [5:0] io_addr = '0;
  logic       io_wr = 1'b0;
  logic [7:0] io_wdata = '0;
  logic [7:0] io_rdata;
  logic       irq_valid;
  logic [1:0] irq_vector;
  logic       irq_ready = 1'b0, reti = 1'b0;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_frontend dut_i (
    .clk, .rst_n, .ext0_n, .ext0_level, .tov_pulse, .io_addr, .io_wr,
    .io_wdata, .io_rdata, .irq_valid, .irq_vector, .irq_ready, .reti
  );

  // behavioural reference model
  bit m_gie = 0, m_en0 = 0, m_ent = 0, m_f0 = 0, m_ft = 0, m_pinq = 1, m_valid = 0;
  int m_vec = 0;

  function automatic logic [7:0] m_read(input logic [5:0] a);
    case (a)
      6'h3B: return m_en0 ? 8'h40 : 8'h00;
      6'h39: return m_ent ? 8'h02 : 8'h00;
      6'h3A: return m_f0  ? 8'h40 : 8'h00;
      6'h38: return m_ft  ? 8'h02 : 8'h00;
      6'h3F: return m_gie ? 8'h80 : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_gie = 0; m_en0 = 0; m_ent = 0; m_f0 = 0; m_ft = 0;
      m_pinq = 1; m_valid = 0; m_vec = 0;
    end else begin
      bit hs, r0, rt, f0, ft, g, v;
      int vec;
      hs = m_valid && irq_ready;
      r0 = m_en0 && (ext0_level ? !ext0_n : m_f0);
      rt = m_ent && m_ft;
      f0 = m_f0; ft = m_ft;
      if (ext0_level) f0 = 0;
      else begin
        if (io_wr && io_addr == 6'h3A && io_wdata[6]) f0 = 0;
        if (hs && m_vec == 1) f0 = 0;
        if (m_pinq && !ext0_n) f0 = 1;
      end
      if (io_wr && io_addr == 6'h38 && io_wdata[1]) ft = 0;
      if (hs && m_vec == 2) ft = 0;
      if (tov_pulse) ft = 1;
      g = m_gie;
      if (io_wr && io_addr == 6'h3F) g = io_wdata[7];
      if (reti) g = 1;
      if (hs) g = 0;
      v = m_valid; vec = m_vec;
      if (hs) v = 0;
      else if (!m_valid && m_gie && (r0 || rt)) begin
        v = 1; vec = r0 ? 1 : 2;
      end
      if (io_wr && io_addr == 6'h3B) m_en0 = io_wdata[6];
      if (io_wr && io_addr == 6'h39) m_ent = io_wdata[1];
      m_f0 = f0; m_ft = ft; m_gie = g; m_valid = v; m_vec = vec;
      m_pinq = ext0_n;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R7 irq_valid vs model", 32'(irq_valid), 32'(m_valid));
      if (m_valid) chk("R5 irq_vector vs model", 32'(irq_vector), 32'(m_vec));
      chk("R2 io_rdata vs model", 32'(io_rdata), 32'(m_read(io_addr)));
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    tick();
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [7:0] exp, input string tag);
    io_addr = a; #1;
    chk(tag, 32'(io_rdata), 32'(exp));
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1 reset state
    rd(6'h3B, 8'h00, "R1 gmask"); rd(6'h39, 8'h00, "R1 tmask");
    rd(6'h3A, 8'h00, "R1 gflag"); rd(6'h38, 8'h00, "R1 tflag");
    rd(6'h3F, 8'h00, "R1 gie");   chk("R1 irq_valid", 32'(irq_valid), 0);
    // R2 map and reserved bits
    wr(6'h3B, 8'hFF); rd(6'h3B, 8'h40, "R2 gmask bit6 only");
    wr(6'h39, 8'hFF); rd(6'h39, 8'h02, "R2 tmask bit1 only");
    wr(6'h10, 8'hFF); rd(6'h10, 8'h00, "R2 unmapped reads zero");
    wr(6'h3F, 8'hFF); rd(6'h3F, 8'h80, "R2 gie bit7");
    wr(6'h3F, 8'h00); wr(6'h3B, 8'h00); wr(6'h39, 8'h00);
    // R3 edge capture while masked
    ext0_n = 1'b0; tick();
    rd(6'h3A, 8'h40, "R3 ext flag on falling edge");
    tov_pulse = 1'b1; tick(); tov_pulse = 1'b0;
    rd(6'h38, 8'h02, "R3 timer flag on pulse");
    chk("R12 no offer while masked", 32'(irq_valid), 0);
    // R4 write-one-to-clear
    wr(6'h3A, 8'h00); rd(6'h3A, 8'h40, "R4 write zero keeps flag");
    wr(6'h3A, 8'h40); rd(6'h3A, 8'h00, "R4 write one clears flag");
    ext0_n = 1'b1; tick();
    ext0_n = 1'b0; wr(6'h3A, 8'h40);
    rd(6'h3A, 8'h40, "R4 event beats clear");
    // R12 / R6 remembered flags, priority
    wr(6'h3B, 8'h40); wr(6'h39, 8'h02);
    chk("R12 no offer with gie off", 32'(irq_valid), 0);
    wr(6'h3F, 8'h80);
    chk("R5 offer one edge after gie", 32'(irq_valid), 0);
    tick();
    chk("R12 remembered flag offered", 32'(irq_valid), 1);
    chk("R6 external first", 32'(irq_vector), 1);
    repeat (3) tick();
    chk("R7 valid held", 32'(irq_valid), 1);
    chk("R7 vector held", 32'(irq_vector), 1);
    // R8 handshake with competing write
    irq_ready = 1'b1; wr(6'h3F, 8'h80); irq_ready = 1'b0;
    chk("R8 offer dropped", 32'(irq_valid), 0);
    rd(6'h3F, 8'h00, "R8 hw clear beats write");
    rd(6'h3A, 8'h00, "R9 ext flag cleared");
    rd(6'h38, 8'h02, "R9 timer flag kept");
    tick(); chk("R8 no offer with gie off", 32'(irq_valid), 0);
    reti = 1'b1; tick(); reti = 1'b0;
    rd(6'h3F, 8'h80, "R10 reti sets gie");
    tick();
    chk("R6 timer next", 32'(irq_valid), 1);
    chk("R5 timer vector", 32'(irq_vector), 2);
    irq_ready = 1'b1; tick(); irq_ready = 1'b0;
    rd(6'h38, 8'h00, "R9 timer flag cleared");
    // R11 level mode
    ext0_level = 1'b1; ext0_n = 1'b1; tick();
    rd(6'h3A, 8'h00, "R11 no flag in level mode");
    reti = 1'b1; tick(); reti = 1'b0;
    repeat (3) tick();
    chk("R11 idle while pin high", 32'(irq_valid), 0);
    ext0_n = 1'b0; tick();
    chk("R11 level request", 32'(irq_valid), 1);
    chk("R11 level vector", 32'(irq_vector), 1);
    rd(6'h3A, 8'h00, "R11 still no flag");
    irq_ready = 1'b1; ext0_n = 1'b1; tick(); irq_ready = 1'b0;
    reti = 1'b1; tick(); reti = 1'b0;
    repeat (2) tick();
    chk("R11 released level not re-offered", 32'(irq_valid), 0);
    ext0_level = 1'b0; tick();
    // random phase, compared against the model every cycle
    for (int n = 0; n < 4000; n++) begin
      int sel;
      logic [5:0] alist [6];
      alist = '{6'h3B, 6'h39, 6'h3A, 6'h38, 6'h3F, 6'h00};
      sel = int'($urandom_range(0, 5));
      ext0_n    = ($urandom_range(0, 3) != 0);
      tov_pulse = ($urandom_range(0, 7) == 0);
      irq_ready = ($urandom_range(0, 2) == 0);
      reti      = ($urandom_range(0, 9) == 0);
      if ($urandom_range(0, 199) == 0) ext0_level = ~ext0_level;
      io_addr  = alist[sel];
      io_wdata = 8'($urandom);
      io_wr    = ($urandom_range(0, 4) == 0);
      tick();
    end
    io_wr = 1'b0; irq_ready = 1'b0; reti = 1'b0; tov_pulse = 1'b0;
    tick();
    finish_run();
  end
endmodule